// File: doc/BRIEF.md
# Port Connection Manager State Machine

This block is the per-phy connection manager that sits between a port-side open/close controller and a link layer. It tracks one connection attempt at a time through three states: Idle, Request Wait and Connected. A request from the controller starts an attempt. Single-cycle confirmation strobes from the link layer then either open the connection, end it, or abandon it. On each exit back to Idle, the block reports the outcome to the controller as a one-cycle message: retry the open, unable to connect, or connection closed.

A hard-reset-received confirmation aborts everything in flight. The block drops any pending request and returns to Idle. It pulses a terminate-all output and forwards the hard reset to the controller, which passes it upward. During a link reset, the teardown confirmations always arrive before the hard reset is recognised, so in practice the machine is already in Idle when the hard reset comes. For that reason the abort is taken in every state, Idle included, and not only in the two busy states.

When several strobes arrive in the same cycle, a fixed priority decides which one acts. All outputs are registered and appear one cycle after the strobe that causes them.

Top module: `conn_mgr_fsm`

## Requirements
- R1: While rst_ni is low, state_o reads 0 (Idle) and every message output and terminate_all_o is 0.
- R2: state_o encodes Idle as 0, Request Wait as 1 and Connected as 2, and never reads 3. In Idle, req_i moves the machine to Request Wait. In Request Wait, open_accept_i moves it to Connected.
- R3: In Request Wait, open_retry_i returns the machine to Idle and raises retry_open_o. In Request Wait, open_fail_i returns it to Idle and raises unable_connect_o.
- R4: In Request Wait, phy_disabled_i returns the machine to Idle and raises no message.
- R5: In Connected, link_closed_i returns the machine to Idle and raises conn_closed_o.
- R6: hard_reset_i in any state, Idle included, puts the machine in Idle and raises both terminate_all_o and hard_reset_fwd_o.
- R7: A hard reset drops any pending request. A req_i in the same cycle as hard_reset_i causes no move to Request Wait, and no retry or unable message follows the abort.
- R8: Strobes arriving in the same cycle act in this order: hard_reset_i first, then phy_disabled_i, then link_closed_i, then open_retry_i, then open_fail_i, then open_accept_i. At most one of retry_open_o, unable_connect_o and conn_closed_o is high in any cycle.
- R9: Every output pulse appears in the cycle after its strobe and lasts exactly one cycle.
- R10: A strobe that has no meaning in the current state is ignored. State and outputs stay unchanged (Idle: everything except req_i and hard_reset_i; Request Wait: req_i and link_closed_i; Connected: everything except link_closed_i and hard_reset_i).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Connection request strobe from the open/close controller |
| open_accept_i | input | 1 | Link strobe: open accepted |
| open_retry_i | input | 1 | Link strobe: open must be retried |
| open_fail_i | input | 1 | Link strobe: open cannot complete |
| phy_disabled_i | input | 1 | Link strobe: phy disabled confirmation |
| link_closed_i | input | 1 | Link strobe: connection closed, transition to idle |
| hard_reset_i | input | 1 | Link strobe: hard reset received |
| retry_open_o | output | 1 | Pulse to the controller: retry the open |
| unable_connect_o | output | 1 | Pulse to the controller: unable to connect |
| conn_closed_o | output | 1 | Pulse to the controller: connection closed |
| hard_reset_fwd_o | output | 1 | Pulse forwarding the hard reset to the controller |
| terminate_all_o | output | 1 | Pulse aborting all outstanding operations |
| state_o | output | 2 | Current state (0 Idle, 1 Request Wait, 2 Connected) |

## Verification
The bench walks the machine along each of its complete paths: request, accept and close; request then retry; request then fail; and request then phy disabled. These separate the three outcome messages from one another and from the silent exit. It also drives a hard reset while the machine is Idle, Request Wait and Connected. This shows the abort is taken in every state and not only in the busy ones. The bench then sends collisions in a single cycle: hard reset with a request, hard reset with a retry, phy disabled with a retry, retry with fail, and hard reset with phy disabled and close. These pin down the priority order. Finally, strobes sent in the wrong state must leave the state and outputs untouched.

// File: rtl/cm_pkg.sv
package cm_pkg;
  localparam int STATE_W = 2;

  typedef enum logic [STATE_W-1:0] {
    ST_IDLE      = 2'd0,
    ST_REQ_WAIT  = 2'd1,
    ST_CONNECTED = 2'd2
  } cm_state_e;

  typedef enum logic [2:0] {
    ACT_NONE,
    ACT_HARD_RESET,
    ACT_PHY_DIS,
    ACT_CLOSE,
    ACT_RETRY,
    ACT_UNABLE,
    ACT_ACCEPT,
    ACT_REQUEST
  } cm_act_e;

  // message vector bit positions
  localparam int MSG_CLOSED = 0;
  localparam int MSG_UNABLE = 1;
  localparam int MSG_RETRY  = 2;
  localparam int MSG_HR_FWD = 3;
  localparam int MSG_TERM   = 4;
  localparam int MSG_W      = 5;
endpackage

// File: rtl/cm_evt_prio.sv
module cm_evt_prio
  import cm_pkg::*;
(
  input  cm_state_e state_i,
  input  logic      req_i,
  input  logic      open_accept_i,
  input  logic      open_retry_i,
  input  logic      open_fail_i,
  input  logic      phy_disabled_i,
  input  logic      link_closed_i,
  input  logic      hard_reset_i,
  output cm_act_e   act_o
);
  // hard reset is taken in every state, Idle included
  always_comb begin
    act_o = ACT_NONE;
    if (hard_reset_i) begin
      act_o = ACT_HARD_RESET;
    end else begin
      unique case (state_i)
        ST_IDLE: begin
          if (req_i) act_o = ACT_REQUEST;
        end
        ST_REQ_WAIT: begin
          if (phy_disabled_i)     act_o = ACT_PHY_DIS;
          else if (open_retry_i)  act_o = ACT_RETRY;
          else if (open_fail_i)   act_o = ACT_UNABLE;
          else if (open_accept_i) act_o = ACT_ACCEPT;
        end
        ST_CONNECTED: begin
          if (link_closed_i) act_o = ACT_CLOSE;
        end
        default: act_o = ACT_NONE;
      endcase
    end
  end
endmodule

// File: rtl/cm_next_state.sv
module cm_next_state
  import cm_pkg::*;
(
  input  cm_state_e        state_i,
  input  cm_act_e          act_i,
  output cm_state_e        state_d_o,
  output logic [MSG_W-1:0] msg_d_o
);
  always_comb begin
    state_d_o = state_i;
    msg_d_o   = '0;
    unique case (act_i)
      ACT_HARD_RESET: begin
        state_d_o          = ST_IDLE;
        msg_d_o[MSG_TERM]   = 1'b1;
        msg_d_o[MSG_HR_FWD] = 1'b1;
      end
      ACT_PHY_DIS: state_d_o = ST_IDLE;
      ACT_CLOSE: begin
        state_d_o           = ST_IDLE;
        msg_d_o[MSG_CLOSED] = 1'b1;
      end
      ACT_RETRY: begin
        state_d_o          = ST_IDLE;
        msg_d_o[MSG_RETRY] = 1'b1;
      end
      ACT_UNABLE: begin
        state_d_o           = ST_IDLE;
        msg_d_o[MSG_UNABLE] = 1'b1;
      end
      ACT_ACCEPT:  state_d_o = ST_CONNECTED;
      ACT_REQUEST: state_d_o = ST_REQ_WAIT;
      default: ;
    endcase
  end
endmodule

// File: rtl/conn_mgr_fsm.sv
module conn_mgr_fsm
  import cm_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_i,
  input  logic               open_accept_i,
  input  logic               open_retry_i,
  input  logic               open_fail_i,
  input  logic               phy_disabled_i,
  input  logic               link_closed_i,
  input  logic               hard_reset_i,
  output logic               retry_open_o,
  output logic               unable_connect_o,
  output logic               conn_closed_o,
  output logic               hard_reset_fwd_o,
  output logic               terminate_all_o,
  output logic [STATE_W-1:0] state_o
);
  cm_state_e        state_q, state_d;
  cm_act_e          act;
  logic [MSG_W-1:0] msg_d, msg_q;

  cm_evt_prio u_prio (
    .state_i       (state_q),
    .req_i         (req_i),
    .open_accept_i (open_accept_i),
    .open_retry_i  (open_retry_i),
    .open_fail_i   (open_fail_i),
    .phy_disabled_i(phy_disabled_i),
    .link_closed_i (link_closed_i),
    .hard_reset_i  (hard_reset_i),
    .act_o         (act)
  );

  cm_next_state u_next (
    .state_i  (state_q),
    .act_i    (act),
    .state_d_o(state_d),
    .msg_d_o  (msg_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  // one pulse flop per message line
  for (genvar g = 0; g < MSG_W; g++) begin : g_msg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) msg_q[g] <= 1'b0;
      else         msg_q[g] <= msg_d[g];
    end
  end

  assign retry_open_o     = msg_q[MSG_RETRY];
  assign unable_connect_o = msg_q[MSG_UNABLE];
  assign conn_closed_o    = msg_q[MSG_CLOSED];
  assign hard_reset_fwd_o = msg_q[MSG_HR_FWD];
  assign terminate_all_o  = msg_q[MSG_TERM];
  assign state_o          = state_q;
endmodule

// File: rtl/cm_fsm_chk.sv
module cm_fsm_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       req_i,
  input logic       open_accept_i,
  input logic       open_retry_i,
  input logic       open_fail_i,
  input logic       phy_disabled_i,
  input logic       link_closed_i,
  input logic       hard_reset_i,
  input logic       retry_open_o,
  input logic       unable_connect_o,
  input logic       conn_closed_o,
  input logic       hard_reset_fwd_o,
  input logic       terminate_all_o,
  input logic [1:0] state_o
);
  AST_STATE_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_o != 2'd3); // R2

  AST_IDLE_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 2'd0 && req_i && !hard_reset_i) |=> state_o == 2'd1); // R2

  AST_WAIT_ACCEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 2'd1 && open_accept_i && !hard_reset_i && !phy_disabled_i
     && !open_retry_i && !open_fail_i) |=> state_o == 2'd2); // R2

  AST_RETRY_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    retry_open_o |-> ($past(state_o) == 2'd1 && $past(open_retry_i)
                      && state_o == 2'd0)); // R3

  AST_PHY_DIS_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 2'd1 && phy_disabled_i && !hard_reset_i)
    |=> (state_o == 2'd0 && !retry_open_o && !unable_connect_o)); // R4

  AST_CLOSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 2'd2 && link_closed_i && !hard_reset_i)
    |=> (state_o == 2'd0 && conn_closed_o)); // R5

  AST_HR_ABORT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hard_reset_i |=> (state_o == 2'd0 && terminate_all_o && hard_reset_fwd_o)); // R6

  AST_HR_NO_MSG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hard_reset_i |=> (!retry_open_o && !unable_connect_o && !conn_closed_o)); // R8

  AST_ONE_MSG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({retry_open_o, unable_connect_o, conn_closed_o})); // R8

  AST_TERM_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    terminate_all_o |-> $past(hard_reset_i)); // R9

  AST_CONN_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 2'd2 && !link_closed_i && !hard_reset_i) |=> state_o == 2'd2); // R10
endmodule

bind conn_mgr_fsm cm_fsm_chk u_chk (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .req_i           (req_i),
  .open_accept_i   (open_accept_i),
  .open_retry_i    (open_retry_i),
  .open_fail_i     (open_fail_i),
  .phy_disabled_i  (phy_disabled_i),
  .link_closed_i   (link_closed_i),
  .hard_reset_i    (hard_reset_i),
  .retry_open_o    (retry_open_o),
  .unable_connect_o(unable_connect_o),
  .conn_closed_o   (conn_closed_o),
  .hard_reset_fwd_o(hard_reset_fwd_o),
  .terminate_all_o (terminate_all_o),
  .state_o         (state_o)
);

// File: tb/conn_mgr_fsm_tb_top.sv
module conn_mgr_fsm_tb_top;
  // input vector {hr, pd, cl, rty, fail, acc, req}
  localparam logic [6:0] I_NONE = 7'b0000000;
  localparam logic [6:0] I_REQ  = 7'b0000001;
  localparam logic [6:0] I_ACC  = 7'b0000010;
  localparam logic [6:0] I_FAIL = 7'b0000100;
  localparam logic [6:0] I_RTY  = 7'b0001000;
  localparam logic [6:0] I_CL   = 7'b0010000;
  localparam logic [6:0] I_PD   = 7'b0100000;
  localparam logic [6:0] I_HR   = 7'b1000000;
  // output vector {term, hr_fwd, retry, unable, closed}
  localparam logic [4:0] O_NONE = 5'b00000;
  localparam logic [4:0] O_CLS  = 5'b00001;
  localparam logic [4:0] O_UNA  = 5'b00010;
  localparam logic [4:0] O_RTY  = 5'b00100;
  localparam logic [4:0] O_HR   = 5'b11000;
  localparam logic [1:0] S_I = 2'd0, S_W = 2'd1, S_C = 2'd2;

  typedef struct {
    string      tag;
    logic [1:0] st;
    logic [4:0] out;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [6:0] drv = '0;
  logic [4:0] outs;
  logic [1:0] state;
  int tests = 0, fails = 0;
  bit done = 0;
  exp_t sb_q[$];

  always #2ns clk = ~clk;

  conn_mgr_fsm dut_i (
    .clk_i           (clk),
    .rst_ni          (rst_n),
    .req_i           (drv[0]),
    .open_accept_i   (drv[1]),
    .open_fail_i     (drv[2]),
    .open_retry_i    (drv[3]),
    .link_closed_i   (drv[4]),
    .phy_disabled_i  (drv[5]),
    .hard_reset_i    (drv[6]),
    .retry_open_o    (outs[2]),
    .unable_connect_o(outs[1]),
    .conn_closed_o   (outs[0]),
    .hard_reset_fwd_o(outs[3]),
    .terminate_all_o (outs[4]),
    .state_o         (state)
  );

  task automatic check(string tag, logic [1:0] est, logic [4:0] eout);
    tests++;
    if (state !== est || outs !== eout) begin
      fails++;
      $display("FAIL %s: state=%0d out=%b expected state=%0d out=%b",
               tag, state, outs, est, eout);
    end
  endtask

  // driver: one strobe pattern per cycle, expectation pushed to scoreboard
  task automatic step(string tag, logic [6:0] in, logic [1:0] est, logic [4:0] eout);
    exp_t e;
    @(negedge clk);
    drv = in;
    e.tag = tag; e.st = est; e.out = eout;
    sb_q.push_back(e);
  endtask

  // monitor: compare just after the edge that consumed the pattern
  always @(posedge clk) begin
    #1ns;
    if (sb_q.size() > 0) begin
      exp_t e;
      e = sb_q.pop_front();
      check(e.tag, e.st, e.out);
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset", S_I, O_NONE);
    rst_n = 1'b1;

    step("R2 idle req",        I_REQ,  S_W, O_NONE);
    step("R2 wait accept",     I_ACC,  S_C, O_NONE);
    step("R10 conn pd ignored", I_PD | I_RTY | I_REQ, S_C, O_NONE);
    step("R5 conn closed",     I_CL,   S_I, O_CLS);
    step("R9 pulse ends",      I_NONE, S_I, O_NONE);
    step("R10 idle stray",     I_ACC | I_RTY | I_CL | I_PD | I_FAIL, S_I, O_NONE);
    step("R2 req",             I_REQ,  S_W, O_NONE);
    step("R10 wait stray",     I_CL | I_REQ, S_W, O_NONE);
    step("R3 retry",           I_RTY,  S_I, O_RTY);
    step("R2 req",             I_REQ,  S_W, O_NONE);
    step("R3 fail",            I_FAIL, S_I, O_UNA);
    step("R2 req",             I_REQ,  S_W, O_NONE);
    step("R8 retry over fail", I_RTY | I_FAIL | I_ACC, S_I, O_RTY);
    step("R2 req",             I_REQ,  S_W, O_NONE);
    step("R4 phy disabled",    I_PD,   S_I, O_NONE);
    step("R2 req",             I_REQ,  S_W, O_NONE);
    step("R8 pd over retry",   I_PD | I_RTY, S_I, O_NONE);
    step("R6 hr in idle",      I_HR,   S_I, O_HR);
    step("R9 hr pulse ends",   I_NONE, S_I, O_NONE);
    step("R7 hr with req",     I_HR | I_REQ, S_I, O_HR);
    step("R7 no late retry",   I_RTY,  S_I, O_NONE);
    step("R2 req",             I_REQ,  S_W, O_NONE);
    step("R8 hr over retry",   I_HR | I_RTY, S_I, O_HR);
    step("R7 no late unable",  I_FAIL, S_I, O_NONE);
    step("R2 req",             I_REQ,  S_W, O_NONE);
    step("R6 hr in wait",      I_HR,   S_I, O_HR);
    step("R2 req",             I_REQ,  S_W, O_NONE);
    step("R2 accept",          I_ACC,  S_C, O_NONE);
    step("R8 hr over pd close", I_HR | I_PD | I_CL, S_I, O_HR);
    step("R9 quiet",           I_NONE, S_I, O_NONE);
    @(negedge clk);
    drv = '0;
    wait (sb_q.size() == 0);
    @(negedge clk);
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      done = 1;
      tests++;
      fails++;
      $display("FAIL watchdog: run did not finish, got hang expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule